// File: doc/BRIEF.md
# Externally Clocked Slave FIFO Port

This block is the slave side of a parallel FIFO port that outside logic drives. The outside master picks one of four FIFOs with a two-bit select. It then moves data with active-low strobes for chip select, read, write, output enable and packet end. Each FIFO is set to byte or 16-bit word transfers by its own configuration bit. Four shallow queues stand behind the port so that transfers, flags and commits can be seen at the pins.

A mode input chooses how read, write and packet end are interpreted. In synchronous mode they are qualifiers sampled on every rising interface clock edge, and the port is meant to run at up to 48 MHz. In asynchronous mode they are free-running strobes. Every pin then passes a two-flop synchronizer, and one transfer happens per strobe, when the strobe returns high. Output enable always acts directly on the data lanes. Packet end reports a commit of the FIFO's current contents: which FIFO it was and how many entries it held.

Top module: `slave_fifo_port`

## Requirements
- R1: While `cs_n` is high, `rd_n`, `wr_n`, `oe_n` and `pktend_n` have no effect: no level changes, no commit pulse, and `dout_en` stays 0.
- R2: `fifo_addr` (value 0 to 3) selects the FIFO that a transfer acts on. A transfer to one FIFO leaves the other three unchanged.
- R3: In synchronous mode (`async_mode`=0), each rising clock edge with `cs_n`=0 and `wr_n`=0 pushes `din`. Each rising edge with `cs_n`=0 and `rd_n`=0 pops the head entry. One transfer happens per edge held.
- R4: In asynchronous mode (`async_mode`=1), a strobe makes exactly one transfer, however long it is held low. The level changes on the third rising clock edge after the strobe's rising edge, and `cs_n` must stay low through that edge.
- R5: A FIFO whose bit in `word_mode` (bit i for FIFO i) is 0 stores only `din[7:0]`. Read data shows that byte on `dout[7:0]`, with `dout[15:8]`=0 and `dout_en`=2'b01.
- R6: A FIFO whose `word_mode` bit is 1 stores all 16 bits and shows them with `dout_en`=2'b11.
- R7: `dout_en` is 2'b00 and `dout` is 0 whenever `cs_n` or `oe_n` is high. Otherwise `dout` shows the head entry of the selected FIFO, with no clock delay.
- R8: A write to a FIFO holding DEPTH (default 4) entries is ignored, and the stored contents stay intact.
- R9: A read from an empty FIFO is ignored. A following write and read return the written value.
- R10: `empty` and `full` describe the FIFO selected by `fifo_addr`. They are registered: a level change made at edge E first shows after edge E+1. They are never both 1.
- R11: A packet-end event raises `commit_valid` for one cycle after the edge at which it occurs. It carries `commit_fifo` and `commit_level`, the FIFO's entry count at that edge. In asynchronous mode, one strobe gives one pulse.
- R12: Each FIFO returns its entries in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| async_mode | input | 1 | 1 = strobe mode, 0 = clock-qualified mode |
| word_mode | input | 4 | Per-FIFO width, 1 = 16-bit word, 0 = byte |
| cs_n | input | 1 | Active-low chip select gating all strobes |
| fifo_addr | input | 2 | FIFO select |
| rd_n | input | 1 | Active-low read |
| wr_n | input | 1 | Active-low write |
| oe_n | input | 1 | Active-low data output enable |
| pktend_n | input | 1 | Active-low packet end |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero on disabled lanes |
| dout_en | output | 2 | Lane drive enables, bit 0 low byte, bit 1 high byte |
| empty | output | 1 | Selected FIFO empty, registered |
| full | output | 1 | Selected FIFO full, registered |
| commit_valid | output | 1 | Packet commit pulse |
| commit_fifo | output | 2 | FIFO committed |
| commit_level | output | 3 | Entries in that FIFO at commit |

## Verification
The results are due at different times:

- `dout` and `dout_en` are combinational on `cs_n`, `oe_n` and `fifo_addr`. The bench reads them 1 ns after it drives those pins.
- A synchronous transfer changes the level at the next rising edge. The flags follow one edge later, so flag checks wait two falling edges. The flag-latency check also confirms the old value after only one.
- In strobe mode, the level moves on the third edge after the strobe rises and the flags on the fourth. The bench checks `empty` unchanged at the third falling edge and changed at the fourth.
- Commit pulses are checked at the falling edge just after the event edge. A bench monitor also counts them, to confirm exactly one pulse per strobe.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int SFP_DW = 16;
  localparam int SFP_AW = 2;
  localparam int SFP_NF = 1 << SFP_AW;

  typedef struct packed {
    logic              cs_n;
    logic              rd_n;
    logic              wr_n;
    logic              pe_n;
    logic [SFP_AW-1:0] addr;
    logic [SFP_DW-1:0] data;
  } pin_snap_t;
endpackage

// File: rtl/sfp_strobe_front.sv
module sfp_strobe_front
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_mode,
  input  pin_snap_t         pins,
  output logic              wr_ev,
  output logic              rd_ev,
  output logic              pe_ev,
  output logic [SFP_AW-1:0] ev_addr,
  output logic [SFP_DW-1:0] ev_data
);
  localparam int NSTG = 3;
  localparam pin_snap_t IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                 pe_n: 1'b1, addr: '0, data: '0};

  pin_snap_t stg   [NSTG];
  pin_snap_t stg_d [NSTG];

  // stage 0/1: synchronizer, stage 2: previous value for edge detection
  always_comb begin
    stg_d[0] = pins;
    for (int k = 1; k < NSTG; k++) stg_d[k] = stg[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSTG; k++) stg[k] <= IDLE;
    end else begin
      for (int k = 0; k < NSTG; k++) stg[k] <= stg_d[k];
    end
  end

  logic a_sel;
  always_comb begin
    a_sel = ~stg[2].cs_n;
    if (async_mode) begin
      wr_ev   = a_sel & stg[1].wr_n & ~stg[2].wr_n;
      rd_ev   = a_sel & stg[1].rd_n & ~stg[2].rd_n;
      pe_ev   = a_sel & stg[1].pe_n & ~stg[2].pe_n;
      ev_addr = stg[2].addr;
      ev_data = stg[2].data;
    end else begin
      wr_ev   = ~pins.cs_n & ~pins.wr_n;
      rd_ev   = ~pins.cs_n & ~pins.rd_n;
      pe_ev   = ~pins.cs_n & ~pins.pe_n;
      ev_addr = pins.addr;
      ev_data = pins.data;
    end
  end
endmodule

// File: rtl/sfp_fifo_bank.sv
module sfp_fifo_bank
  import sfp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_ev,
  input  logic                             rd_ev,
  input  logic [SFP_AW-1:0]                ev_addr,
  input  logic [SFP_DW-1:0]                ev_data,
  input  logic [SFP_NF-1:0]                word_mode,
  output logic [SFP_NF-1:0][SFP_DW-1:0]    head,
  output logic [SFP_NF-1:0][LW-1:0]        lvl
);
  localparam int HB = SFP_DW / 2;

  for (genvar g = 0; g < SFP_NF; g++) begin : g_fifo
    logic [SFP_DW-1:0] mem [DEPTH];
    logic [PW-1:0]     wp, wp_d, rp, rp_d;
    logic [LW-1:0]     cnt, cnt_d;
    logic              hit, push, pop;
    logic [SFP_DW-1:0] wdata;

    always_comb begin
      hit   = (ev_addr == SFP_AW'(g));
      push  = wr_ev & hit & (cnt != LW'(DEPTH));
      pop   = rd_ev & hit & (cnt != '0);
      wdata = word_mode[g] ? ev_data : {{HB{1'b0}}, ev_data[HB-1:0]};
      wp_d  = wp;
      rp_d  = rp;
      cnt_d = cnt;
      if (push) wp_d = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp_d = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop) cnt_d = cnt + 1'b1;
      if (pop && !push) cnt_d = cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        wp  <= wp_d;
        rp  <= rp_d;
        cnt <= cnt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
    end

    assign head[g] = mem[rp];
    assign lvl[g]  = cnt;
  end
endmodule

// File: rtl/sfp_flag_reg.sv
module sfp_flag_reg
  import sfp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SFP_AW-1:0]         sel_addr,
  input  logic [SFP_NF-1:0][LW-1:0] lvl,
  input  logic                      pe_ev,
  input  logic [SFP_AW-1:0]         ev_addr,
  output logic                      empty,
  output logic                      full,
  output logic                      commit_valid,
  output logic [SFP_AW-1:0]         commit_fifo,
  output logic [LW-1:0]             commit_level
);
  logic              empty_d, full_d, cv_d;
  logic [SFP_AW-1:0] cf_d;
  logic [LW-1:0]     cl_d, sel_lvl;

  always_comb begin
    sel_lvl = lvl[sel_addr];
    empty_d = (sel_lvl == '0);
    full_d  = (sel_lvl == LW'(DEPTH));
    cv_d    = pe_ev;
    cf_d    = pe_ev ? ev_addr : commit_fifo;
    cl_d    = pe_ev ? lvl[ev_addr] : commit_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty        <= 1'b1;
      full         <= 1'b0;
      commit_valid <= 1'b0;
      commit_fifo  <= '0;
      commit_level <= '0;
    end else begin
      empty        <= empty_d;
      full         <= full_d;
      commit_valid <= cv_d;
      commit_fifo  <= cf_d;
      commit_level <= cl_d;
    end
  end
endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port
  import sfp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_mode,
  input  logic [SFP_NF-1:0] word_mode,
  input  logic              cs_n,
  input  logic [SFP_AW-1:0] fifo_addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              pktend_n,
  input  logic [SFP_DW-1:0] din,
  output logic [SFP_DW-1:0] dout,
  output logic [1:0]        dout_en,
  output logic              empty,
  output logic              full,
  output logic              commit_valid,
  output logic [SFP_AW-1:0] commit_fifo,
  output logic [LVL_W-1:0]  commit_level
);
  localparam int HB = SFP_DW / 2;

  logic [1:0] rst_sr;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_q_n = rst_sr[1];

  pin_snap_t pins;
  assign pins = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, pe_n: pktend_n,
                  addr: fifo_addr, data: din};

  logic              wr_ev, rd_ev, pe_ev;
  logic [SFP_AW-1:0] ev_addr;
  logic [SFP_DW-1:0] ev_data;

  sfp_strobe_front u_front (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .async_mode (async_mode),
    .pins       (pins),
    .wr_ev      (wr_ev),
    .rd_ev      (rd_ev),
    .pe_ev      (pe_ev),
    .ev_addr    (ev_addr),
    .ev_data    (ev_data)
  );

  logic [SFP_NF-1:0][SFP_DW-1:0] head_w;
  logic [SFP_NF-1:0][LVL_W-1:0]  lvl_w;

  sfp_fifo_bank #(.DEPTH(DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_ev     (wr_ev),
    .rd_ev     (rd_ev),
    .ev_addr   (ev_addr),
    .ev_data   (ev_data),
    .word_mode (word_mode),
    .head      (head_w),
    .lvl       (lvl_w)
  );

  sfp_flag_reg #(.DEPTH(DEPTH)) u_flags (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .sel_addr     (fifo_addr),
    .lvl          (lvl_w),
    .pe_ev        (pe_ev),
    .ev_addr      (ev_addr),
    .empty        (empty),
    .full         (full),
    .commit_valid (commit_valid),
    .commit_fifo  (commit_fifo),
    .commit_level (commit_level)
  );

  logic oe_act;
  always_comb begin
    oe_act  = ~cs_n & ~oe_n;
    dout_en = oe_act ? (word_mode[fifo_addr] ? 2'b11 : 2'b01) : 2'b00;
    dout    = head_w[fifo_addr] & {{HB{dout_en[1]}}, {HB{dout_en[0]}}};
  end
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker
  import sfp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      async_mode,
  input logic                      cs_n,
  input logic                      oe_n,
  input logic [SFP_DW-1:0]         dout,
  input logic [1:0]                dout_en,
  input logic                      empty,
  input logic                      full,
  input logic                      commit_valid,
  input logic [SFP_NF-1:0][LW-1:0] lvl
);
  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || oe_n) |-> (dout_en == 2'b00 && dout == '0));

  // R5
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en == 2'b01) |-> (dout[SFP_DW-1:SFP_DW/2] == '0));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R11
  commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && commit_valid) |=> !commit_valid);

  // R1
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && cs_n) |=> ($stable(lvl) && !commit_valid));

  for (genvar g = 0; g < SFP_NF; g++) begin : g_lvl
    // R8
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[g] <= LW'(DEPTH));
    // R3
    lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[g] == $past(lvl[g])) || (lvl[g] == $past(lvl[g]) + 1'b1) ||
      ($past(lvl[g]) == lvl[g] + 1'b1));
  end
endmodule

bind slave_fifo_port sfp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .async_mode   (async_mode),
  .cs_n         (cs_n),
  .oe_n         (oe_n),
  .dout         (dout),
  .dout_en      (dout_en),
  .empty        (empty),
  .full         (full),
  .commit_valid (commit_valid),
  .lvl          (lvl_w)
);

// File: tb/test_slave_fifo_port.sv
module test_slave_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n, async_mode, cs_n, rd_n, wr_n, oe_n, pktend_n;
  logic [3:0]  word_mode;
  logic [1:0]  fifo_addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic        empty, full, commit_valid;
  logic [1:0]  commit_fifo;
  logic [2:0]  commit_level;

  int checks = 0;
  int errors = 0;
  int n_commit = 0;
  logic [1:0] last_cf;
  logic [2:0] last_cl;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_fifo_port #(.DEPTH(DEPTH)) i_slave_fifo_port (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .word_mode(word_mode),
    .cs_n(cs_n), .fifo_addr(fifo_addr), .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n),
    .pktend_n(pktend_n), .din(din), .dout(dout), .dout_en(dout_en),
    .empty(empty), .full(full), .commit_valid(commit_valid),
    .commit_fifo(commit_fifo), .commit_level(commit_level)
  );

  always @(negedge clk) begin
    if (commit_valid === 1'b1) begin
      n_commit++;
      last_cf = commit_fifo;
      last_cl = commit_level;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int f, input int i);
    return 16'(((f + 1) * 16'h1357) ^ (i * 16'h0421) ^ 16'h8000);
  endfunction

  function automatic logic [15:0] masked(input logic [15:0] v, input bit word);
    return word ? v : {8'h00, v[7:0]};
  endfunction

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw(input int f, input logic [15:0] v);
    cs_n = 0; wr_n = 0; fifo_addr = 2'(f); din = v;
    nclk(1);
    wr_n = 1; cs_n = 1;
  endtask

  task automatic sr(input int f, input logic [15:0] exp, input bit word,
                    input bit check, input string req);
    cs_n = 0; oe_n = 0; fifo_addr = 2'(f);
    #1;
    if (check) begin
      chk(req, dout, masked(exp, word));
      chk(word ? "R6 lanes" : "R5 lanes", dout_en, word ? 2'b11 : 2'b01);
    end
    rd_n = 0;
    nclk(1);
    rd_n = 1; oe_n = 1; cs_n = 1;
  endtask

  task automatic aw(input int f, input logic [15:0] v);
    cs_n = 0; wr_n = 0; fifo_addr = 2'(f); din = v;
    nclk(4);
    wr_n = 1;
    nclk(4);
    cs_n = 1;
  endtask

  task automatic ar(input int f, input logic [15:0] exp, input bit word, input string req);
    cs_n = 0; oe_n = 0; fifo_addr = 2'(f);
    #1;
    chk(req, dout, masked(exp, word));
    rd_n = 0;
    nclk(4);
    rd_n = 1;
    nclk(4);
    oe_n = 1; cs_n = 1;
  endtask

  task automatic flags(input int f, input bit e, input bit fl, input string req);
    fifo_addr = 2'(f);
    nclk(2);
    chk(req, {empty, full}, {e, fl});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nc;
    bit wd;
    rst_n = 0; async_mode = 0; word_mode = 4'h0; cs_n = 1; rd_n = 1; wr_n = 1;
    oe_n = 1; pktend_n = 1; fifo_addr = 0; din = 0;
    nclk(3);
    rst_n = 1;
    nclk(4);
    chk("reset flags", {empty, full, commit_valid}, 3'b100);
    chk("reset lanes R7", dout_en, 2'b00);

    // R1: strobes without chip select
    nc = n_commit;
    cs_n = 1; wr_n = 0; rd_n = 0; oe_n = 0; pktend_n = 0; fifo_addr = 1; din = 16'hBEEF;
    #1;
    chk("R1 oe gated", {dout_en, dout}, 18'h0);
    nclk(4);
    wr_n = 1; rd_n = 1; oe_n = 1; pktend_n = 1;
    chk("R1 no commit", n_commit - nc, 0);
    flags(1, 1, 0, "R1 no write");

    // R7: oe high with chip select low
    cs_n = 0; oe_n = 1; #1;
    chk("R7 oe off", {dout_en, dout}, 18'h0);
    cs_n = 1;

    // synchronous sweep over width and FIFO
    for (int w = 0; w < 2; w++) begin
      word_mode = w ? 4'hF : 4'h0;
      for (int f = 0; f < 4; f++) begin
        for (int i = 0; i <= DEPTH; i++) sw(f, pat(f, i));
        flags(f, 0, 1, "R8 full flag");
        for (int g = 0; g < 4; g++)
          if (g != f) flags(g, 1, 0, "R2 other FIFO untouched");
        for (int i = 0; i < DEPTH; i++) sr(f, pat(f, i), w[0], 1, "R12 order/R8 contents");
        flags(f, 1, 0, "R9 empty after drain");
        sr(f, 0, w[0], 0, "");
        flags(f, 1, 0, "R9 read empty ignored");
        sw(f, pat(f, 9));
        sr(f, pat(f, 9), w[0], 1, "R9 after underflow");
      end
    end

    // R3: held write strobe gives one push per edge
    word_mode = 4'b0101;
    cs_n = 0; wr_n = 0; fifo_addr = 0; din = 16'h1234;
    nclk(3);
    wr_n = 1; cs_n = 1;
    for (int i = 0; i < 3; i++) sr(0, 16'h1234, 1, 1, "R3 held write");
    flags(0, 1, 0, "R3 three pushes");

    // R10: flag latency
    cs_n = 0; wr_n = 0; fifo_addr = 1; din = 16'h00A5;
    nclk(1);
    wr_n = 1; cs_n = 1;
    chk("R10 flag not yet", empty, 1'b1);
    nclk(1);
    chk("R10 flag after one more edge", empty, 1'b0);

    // R11: synchronous packet end on FIFO 1 with two entries
    sw(1, 16'h00C3);
    cs_n = 0; pktend_n = 0; fifo_addr = 1;
    nclk(1);
    chk("R11 sync commit", {commit_valid, commit_fifo, commit_level}, {1'b1, 2'd1, 3'd2});
    pktend_n = 1; cs_n = 1;
    nclk(1);
    chk("R11 pulse ends", commit_valid, 1'b0);
    sr(1, 16'h00A5, 0, 1, "R5 byte FIFO");
    sr(1, 16'h00C3, 0, 1, "R5 byte FIFO");

    // asynchronous mode
    async_mode = 1;
    word_mode = 4'b1010;
    nclk(4);
    cs_n = 0; wr_n = 0; fifo_addr = 2; din = 16'h5A5A;
    nclk(10);
    wr_n = 1;
    nclk(3);
    chk("R4 flag before", empty, 1'b1);
    nclk(1);
    chk("R4 one transfer on release", empty, 1'b0);
    cs_n = 1;
    ar(2, 16'h5A5A, 0, "R4 async byte data");
    flags(2, 1, 0, "R4 single transfer");

    for (int f = 0; f < 4; f++) begin
      wd = word_mode[f];
      for (int i = 0; i < DEPTH; i++) aw(f, pat(f, i + 5));
      flags(f, 0, 1, "R4 async full");
      aw(f, 16'hFFFF);
      for (int i = 0; i < DEPTH; i++) ar(f, pat(f, i + 5), wd, "R4 async order");
      flags(f, 1, 0, "R4 async drained");
    end

    // R11: asynchronous packet end on FIFO 3 with three entries
    for (int i = 0; i < 3; i++) aw(3, pat(3, i));
    nc = n_commit;
    cs_n = 0; pktend_n = 0; fifo_addr = 3;
    nclk(6);
    pktend_n = 1;
    nclk(5);
    cs_n = 1;
    chk("R11 async one pulse", n_commit - nc, 1);
    chk("R11 async fifo/level", {last_cf, last_cl}, {2'd3, 3'd3});

    // R1 in async mode
    nc = n_commit;
    cs_n = 1; pktend_n = 0; rd_n = 0; fifo_addr = 3;
    nclk(5);
    pktend_n = 1; rd_n = 1;
    nclk(5);
    chk("R1 async no commit", n_commit - nc, 0);
    ar(3, pat(3, 0), 1, "R1 async no read");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule